// File: doc/BRIEF.md
# Serial EEPROM Bus Slave Controller

This block is the bus-side engine of a byte-addressed nonvolatile memory that answers as a slave on a two-wire I2C bus. It synchronizes the raw clock and data lines, spots Start and Stop conditions, and decodes the select byte. It then takes a two-byte memory address and carries out single-byte writes, page writes, random reads, current-address reads and sequential reads. It answers on SDA only by pulling the line low, for acknowledge bits and for read data.

Writes do not reach the storage directly. Each accepted data byte is handed to a write-commit engine as a strobe with address and data. A Stop that closes a write with at least one accepted byte raises a one-cycle commit request. While the engine reports busy, the controller ignores the bus and leaves every select byte unacknowledged. Reads fetch from a combinational array port addressed by the controller's internal address counter. That one counter serves random, current-address and sequential reads.

Top module: `i2c_mem_slave`

## Requirements
- R1: After reset, SDA is released (`sda_pull`=0) and `wr_stb` and `commit_req` are low.
- R2: A select byte is acknowledged only when its upper seven bits equal binary 1010 followed by `ce_strap` (MSB first); bit 0 is the direction, 1 meaning read. A non-matching select byte is not acknowledged, and the bytes that follow it up to the next Start are not acknowledged either.
- R3: The controller pulls SDA low during the ninth clock to acknowledge a byte. It releases SDA after that clock, and it changes its SDA drive only while SCL is low.
- R4: Select (write), address high, address low, one data byte and Stop produce one `wr_stb` carrying that address and byte, followed by a single-cycle `commit_req`.
- R5: In a page write, each further data byte goes to the next address. Only the low five address bits advance, wrapping within the 32-byte page.
- R6: While `wr_lock` is high, the select and address bytes are acknowledged, data bytes are not, no `wr_stb` or `commit_req` appears, and the memory is unchanged.
- R7: A random read (select write, two address bytes, repeated Start, select read) returns the byte at the sent address.
- R8: A current-address read returns the byte after the last one transferred, because the counter advances after each byte sent.
- R9: In a sequential read, each master acknowledge yields the next byte. The 13-bit address wraps from 0x1FFF to 0x0000, and a master NoAck ends the transfer.
- R10: While `busy_in` is high, select bytes are not acknowledged.
- R11: The top three bits of the high address byte are ignored.
- R12: A Stop or Start that comes before any accepted data byte returns the controller to idle without `commit_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Raw bus clock line |
| sda_in | input | 1 | Raw bus data line |
| ce_strap | input | 3 | Chip-enable strap compared with select bits 3..1 |
| wr_lock | input | 1 | High blocks data writes |
| busy_in | input | 1 | Commit engine is writing |
| rd_data | input | 8 | Array byte at `rd_addr` |
| sda_pull | output | 1 | 1 pulls SDA low |
| rd_addr | output | 13 | Internal address counter |
| wr_stb | output | 1 | One-cycle strobe of an accepted data byte |
| wr_addr | output | 13 | Address of the strobed byte |
| wr_data | output | 8 | Strobed data byte |
| commit_req | output | 1 | One-cycle request to commit buffered bytes |

## Verification
The bench sweeps all eight chip-enable values and a wrong prefix. A decoder that ignored the strap or the prefix would acknowledge foreign select bytes. A controller that did not fall silent after a mismatch would acknowledge the following byte. A page write that starts two bytes before the page end must land its last two bytes at the start of the same page; a counter carrying into bit 5 would corrupt the next page. A sequential read across 0x1FFF checks the full-width wrap. A locked write checks both the NoAck and the absence of strobes and commits, so a controller that only dropped the acknowledge would be caught. Select bytes sent during the busy window, and a commit count taken after aborted transfers, catch a controller that answers while busy or commits without data.

// File: rtl/i2cm_pkg.sv
// Shared constants and the sequencer state type for the bus slave.
package i2cm_pkg;
    localparam int CE_W = 3;
    localparam logic [3:0] DEV_PREFIX = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEVSEL,
        ST_AHI,
        ST_ALO,
        ST_WDATA,
        ST_RDATA
    } ctl_state_t;
endpackage

// File: rtl/i2cm_line_sync.sv
// Brings raw SCL/SDA into the clock domain through a flop chain and
// derives edge, Start and Stop events. Assumes the bus idles high and the
// bus clock is many system clocks long.
module i2cm_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_chain;
    logic [STAGES-1:0] sda_chain;
    logic scl_q;
    logic sda_q;

    // Shift raw lines through the synchronizer and keep one delayed copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_chain <= '1;
            sda_chain <= '1;
            scl_q     <= 1'b1;
            sda_q     <= 1'b1;
        end else begin
            scl_chain <= {scl_chain[STAGES-2:0], scl_raw};
            sda_chain <= {sda_chain[STAGES-2:0], sda_raw};
            scl_q     <= scl_chain[STAGES-1];
            sda_q     <= sda_chain[STAGES-1];
        end
    end

    // Event decode from current and previous synchronized samples.
    always_comb begin
        scl_s     = scl_chain[STAGES-1];
        sda_s     = sda_chain[STAGES-1];
        scl_rise  = scl_s & ~scl_q;
        scl_fall  = ~scl_s & scl_q;
        start_det = scl_s & scl_q & sda_q & ~sda_s;
        stop_det  = scl_s & scl_q & ~sda_q & sda_s;
    end
endmodule

// File: rtl/i2cm_addr_ctr.sv
// Memory address counter: loaded from the two address bytes, advanced by
// whole width for reads and within the page for writes. Assumes ADDR_W > 8.
module i2cm_addr_ctr #(
    parameter int ADDR_W = 13,
    parameter int PAGE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        byte_in,
    input  logic              ld_hi,
    input  logic              ld_lo,
    input  logic              inc_seq,
    input  logic              inc_page,
    output logic [ADDR_W-1:0] addr_q
);
    localparam int HI_W = ADDR_W - 8;

    logic [HI_W-1:0] hi_q;

    // Hold the high address part until the low byte arrives.
    always_ff @(posedge clk) begin
        if (!rst_n)     hi_q <= '0;
        else if (ld_hi) hi_q <= byte_in[HI_W-1:0];
    end

    // Load, full-width increment or in-page increment of the counter.
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr_q <= '0;
        else if (ld_lo)
            addr_q <= {hi_q, byte_in};
        else if (inc_seq)
            addr_q <= addr_q + 1'b1;
        else if (inc_page)
            addr_q <= {addr_q[ADDR_W-1:PAGE_W], addr_q[PAGE_W-1:0] + 1'b1};
    end

    // R5
    page_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inc_page |=> (addr_q[ADDR_W-1:PAGE_W] == $past(addr_q[ADDR_W-1:PAGE_W])));
endmodule

// File: rtl/i2c_mem_slave.sv
// Bus slave sequencer for a serial memory: select decode, address capture,
// write hand-off and read serialization. Samples SDA on SCL rise, changes
// its SDA drive on SCL fall. Assumes an external commit engine that raises
// busy_in after commit_req and a combinational read port.
module i2c_mem_slave
    import i2cm_pkg::*;
#(
    parameter int ADDR_W      = 13,
    parameter int PAGE_W      = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic [CE_W-1:0]   ce_strap,
    input  logic              wr_lock,
    input  logic              busy_in,
    input  logic [7:0]        rd_data,
    output logic              sda_pull,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              commit_req
);
    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    ctl_state_t state;
    logic [3:0] bitcnt;
    logic [7:0] shreg;
    logic       has_data;
    logic       rx_st, eval, devsel_ok, load_rd;
    logic       ld_hi, ld_lo, inc_page;
    logic [ADDR_W-1:0] addr;

    i2cm_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_raw(scl_in), .sda_raw(sda_in),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2cm_addr_ctr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_actr (
        .clk(clk), .rst_n(rst_n), .byte_in(shreg), .ld_hi(ld_hi), .ld_lo(ld_lo),
        .inc_seq(load_rd), .inc_page(inc_page), .addr_q(addr)
    );

    // Byte-boundary decode shared by the sequencer and the address counter.
    always_comb begin
        rx_st     = (state == ST_DEVSEL) || (state == ST_AHI) ||
                    (state == ST_ALO) || (state == ST_WDATA);
        eval      = scl_fall && rx_st && (bitcnt == 4'd8);
        devsel_ok = (shreg[7:1] == {DEV_PREFIX, ce_strap}) && !busy_in;
        load_rd   = scl_fall && (state == ST_RDATA) && (bitcnt == 4'd9);
        ld_hi     = eval && (state == ST_AHI);
        ld_lo     = eval && (state == ST_ALO);
        inc_page  = eval && (state == ST_WDATA) && !wr_lock;
        rd_addr   = addr;
    end

    // Protocol sequencer: bit counting, acknowledge and data drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            bitcnt     <= '0;
            shreg      <= '0;
            sda_pull   <= 1'b0;
            has_data   <= 1'b0;
            wr_stb     <= 1'b0;
            wr_addr    <= '0;
            wr_data    <= '0;
            commit_req <= 1'b0;
        end else begin
            wr_stb     <= 1'b0;
            commit_req <= 1'b0;
            if (start_det) begin
                state    <= ST_DEVSEL;
                bitcnt   <= '0;
                sda_pull <= 1'b0;
                has_data <= 1'b0;
            end else if (stop_det) begin
                if (state == ST_WDATA && has_data) commit_req <= 1'b1;
                state    <= ST_IDLE;
                sda_pull <= 1'b0;
                has_data <= 1'b0;
            end else if (rx_st) begin
                if (scl_rise) begin
                    if (bitcnt < 4'd8) begin
                        shreg  <= {shreg[6:0], sda_s};
                        bitcnt <= bitcnt + 4'd1;
                    end else if (bitcnt == 4'd8) begin
                        bitcnt <= 4'd9;
                    end
                end else if (scl_fall) begin
                    if (bitcnt == 4'd8) begin
                        case (state)
                            ST_DEVSEL: begin
                                if (devsel_ok) begin
                                    sda_pull <= 1'b1;
                                    state    <= shreg[0] ? ST_RDATA : ST_AHI;
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end
                            ST_AHI: begin
                                sda_pull <= 1'b1;
                                state    <= ST_ALO;
                            end
                            ST_ALO: begin
                                sda_pull <= 1'b1;
                                state    <= ST_WDATA;
                            end
                            default: begin
                                if (!wr_lock) begin
                                    sda_pull <= 1'b1;
                                    wr_stb   <= 1'b1;
                                    wr_addr  <= addr;
                                    wr_data  <= shreg;
                                    has_data <= 1'b1;
                                end
                            end
                        endcase
                    end else if (bitcnt == 4'd9) begin
                        sda_pull <= 1'b0;
                        bitcnt   <= '0;
                    end
                end
            end else if (state == ST_RDATA) begin
                if (scl_rise) begin
                    if (bitcnt < 4'd8) begin
                        bitcnt <= bitcnt + 4'd1;
                    end else if (bitcnt == 4'd8) begin
                        if (!sda_s) bitcnt <= 4'd9;
                        else        state  <= ST_IDLE;
                    end
                end else if (scl_fall) begin
                    if (bitcnt == 4'd9) begin
                        shreg    <= rd_data;
                        sda_pull <= ~rd_data[7];
                        bitcnt   <= '0;
                    end else if (bitcnt >= 4'd1 && bitcnt <= 4'd7) begin
                        shreg    <= {shreg[6:0], 1'b0};
                        sda_pull <= ~shreg[6];
                    end else if (bitcnt == 4'd8) begin
                        sda_pull <= 1'b0;
                    end
                end
            end
        end
    end

    // R3
    sda_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_pull != $past(sda_pull)) |-> (!$past(scl_s) || $past(start_det) || $past(stop_det)));
    // R4
    commit_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_req |=> !commit_req);
    // R12
    commit_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_req |-> $past(stop_det));
    // R6
    lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> !$past(wr_lock));
    // R10
    busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_in && eval && state == ST_DEVSEL) |=> !sda_pull);
endmodule

// File: tb/i2c_mem_slave_tb.sv
module i2c_mem_slave_tb;
    localparam int CLK_PERIOD = 10;
    localparam int H = 8;
    localparam int BUSY_CYC = 600;
    localparam logic [2:0] CE = 3'b101;
    localparam logic [7:0] DEV_W = {4'b1010, CE, 1'b0};
    localparam logic [7:0] DEV_R = {4'b1010, CE, 1'b1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic wr_lock = 1'b0;
    logic busy;
    logic [7:0] rd_data;
    logic sda_pull, wr_stb, commit_req;
    logic [12:0] rd_addr, wr_addr;
    logic [7:0] wr_data;
    logic sda_bus;

    int total = 0, bad = 0;
    int n_stb = 0, n_commit = 0;
    int busy_cnt = 0;
    logic [12:0] last_wa = '0;
    logic [7:0]  last_wd = '0;
    logic [12:0] pa [32];
    logic [7:0]  pd [32];
    int pn = 0;
    logic [12:0] ov_a [64];
    logic [7:0]  ov_d [64];
    int ov_n = 0;
    logic [12:0] ex_a [16];
    logic [7:0]  ex_d [16];
    int ex_n = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign sda_bus = sda_m & ~sda_pull;
    assign busy = (busy_cnt != 0);

    i2c_mem_slave u_dut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus),
        .ce_strap(CE), .wr_lock(wr_lock), .busy_in(busy), .rd_data(rd_data),
        .sda_pull(sda_pull), .rd_addr(rd_addr), .wr_stb(wr_stb),
        .wr_addr(wr_addr), .wr_data(wr_data), .commit_req(commit_req)
    );

    function automatic logic [7:0] base_val(int a);
        int v;
        v = (a * 37 + 11) ^ (a >> 5);
        return v[7:0];
    endfunction

    function automatic logic [7:0] exp_at(int a);
        logic [7:0] d;
        d = base_val(a);
        for (int k = 0; k < 16; k++) if (k < ex_n && ex_a[k] == a[12:0]) d = ex_d[k];
        return d;
    endfunction

    // Array model: base pattern with committed overrides.
    always_comb begin
        rd_data = base_val(int'(rd_addr));
        for (int k = 0; k < 64; k++) if (k < ov_n && ov_a[k] == rd_addr) rd_data = ov_d[k];
    end

    // Commit engine model: buffer strobes, apply on request, hold busy.
    always @(posedge clk) begin
        if (wr_stb) begin
            if (pn < 32) begin pa[pn] <= wr_addr; pd[pn] <= wr_data; pn <= pn + 1; end
            n_stb <= n_stb + 1; last_wa <= wr_addr; last_wd <= wr_data;
        end
        if (commit_req) begin
            for (int k = 0; k < 32; k++)
                if (k < pn && ov_n + k < 64) begin ov_a[ov_n+k] <= pa[k]; ov_d[ov_n+k] <= pd[k]; end
            ov_n <= ov_n + pn; pn <= 0; busy_cnt <= BUSY_CYC; n_commit <= n_commit + 1;
        end else if (busy_cnt > 0) busy_cnt <= busy_cnt - 1;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic hw(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; hw(H); scl_m = 1'b1; hw(H); sda_m = 1'b0; hw(H); scl_m = 1'b0; hw(H);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; hw(H); scl_m = 1'b1; hw(H); sda_m = 1'b1; hw(H);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; hw(H); scl_m = 1'b1; hw(H); scl_m = 1'b0;
        end
        sda_m = 1'b1; hw(H); scl_m = 1'b1; hw(H/2);
        acked = !sda_bus;
        hw(H/2); scl_m = 1'b0;
    endtask

    task automatic recv_byte(output logic [7:0] b, input bit mack);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            hw(H); scl_m = 1'b1; hw(H/2); b[i] = sda_bus; hw(H/2); scl_m = 1'b0;
        end
        sda_m = !mack; hw(H); scl_m = 1'b1; hw(H); scl_m = 1'b0; sda_m = 1'b1;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        hw(4);
    endtask

    // Address phase of a write transfer; reports acks of all three bytes.
    task automatic addr_phase(input logic [7:0] hi, input logic [7:0] lo, input string tag);
        bit a;
        bus_start();
        send_byte(DEV_W, a); chk(a, {tag, " select ack"}, a, 1);
        send_byte(hi, a);    chk(a, {tag, " high addr ack"}, a, 1);
        send_byte(lo, a);    chk(a, {tag, " low addr ack"}, a, 1);
    endtask

    task automatic rd_check(input logic [7:0] hi, input logic [7:0] lo, input int n,
                            input int a0, input string tag);
        bit a;
        logic [7:0] b;
        addr_phase(hi, lo, tag);
        bus_start();
        send_byte(DEV_R, a); chk(a, {tag, " read select ack"}, a, 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(b, i < n - 1);
            chk(b == exp_at((a0 + i) % 8192), tag, b, exp_at((a0 + i) % 8192));
        end
        bus_stop();
    endtask

    task automatic cur_check(input int n, input int a0, input string tag);
        bit a;
        logic [7:0] b;
        bus_start();
        send_byte(DEV_R, a); chk(a, {tag, " select ack"}, a, 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(b, i < n - 1);
            chk(b == exp_at((a0 + i) % 8192), tag, b, exp_at((a0 + i) % 8192));
        end
        bus_stop();
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired actual=0x0 expected=0x1");
        summary();
    end

    initial begin
        bit a;
        int c0, s0;
        hw(6);
        rst_n = 1'b1;
        hw(4);
        // R1
        chk(!sda_pull && !wr_stb && !commit_req, "R1 reset outputs", {sda_pull, wr_stb, commit_req}, 0);

        // R2: sweep all chip-enable codes with the fixed prefix
        for (int ce = 0; ce < 8; ce++) begin
            bus_start();
            send_byte({4'b1010, 3'(ce), 1'b0}, a);
            chk(a == (ce == int'(CE)), "R2 select match sweep", a, ce == int'(CE));
            bus_stop();
        end
        // R2: wrong prefix rejected and the next byte ignored
        bus_start();
        send_byte({4'b1011, CE, 1'b0}, a); chk(!a, "R2 wrong prefix", a, 0);
        send_byte(8'h00, a);               chk(!a, "R2 byte after mismatch", a, 0);
        bus_stop();

        // R4: single byte write
        c0 = n_commit; s0 = n_stb;
        addr_phase(8'h01, 8'h23, "R4");
        send_byte(8'h5A, a); chk(a, "R4 data ack", a, 1);
        hw(H);
        // R3
        chk(!sda_pull, "R3 release after ack clock", sda_pull, 0);
        bus_stop();
        hw(2);
        chk(n_stb == s0 + 1 && last_wa == 13'h0123 && last_wd == 8'h5A, "R4 strobe",
            {last_wa, last_wd}, {13'h0123, 8'h5A});
        chk(n_commit == c0 + 1, "R4 commit count", n_commit, c0 + 1);
        ex_a[ex_n] = 13'h0123; ex_d[ex_n] = 8'h5A; ex_n++;
        // R10: select while busy
        bus_start();
        send_byte(DEV_W, a); chk(!a, "R10 select nack while busy", a, 0);
        bus_stop();
        chk(busy, "R10 still busy during probe", busy, 1);
        wait_idle();
        // R7
        rd_check(8'h01, 8'h23, 1, 13'h0123, "R7 random read");

        // R5: page write wrapping inside the page
        c0 = n_commit;
        addr_phase(8'h04, 8'h5E, "R5");
        for (int i = 0; i < 4; i++) begin
            send_byte(8'hC0 + 8'(i), a); chk(a, "R5 data ack", a, 1);
            ex_a[ex_n] = {8'h22, 5'((30 + i) % 32)}; ex_d[ex_n] = 8'hC0 + 8'(i); ex_n++;
        end
        bus_stop();
        hw(2);
        chk(n_commit == c0 + 1, "R5 commit count", n_commit, c0 + 1);
        wait_idle();
        rd_check(8'h04, 8'h40, 3, 13'h0440, "R5 page wrap head");
        rd_check(8'h04, 8'h5E, 2, 13'h045E, "R5 page tail");

        // R6: locked write
        c0 = n_commit; s0 = n_stb;
        wr_lock = 1'b1;
        addr_phase(8'h02, 8'h00, "R6");
        send_byte(8'h77, a); chk(!a, "R6 data nack", a, 0);
        send_byte(8'h78, a); chk(!a, "R6 second data nack", a, 0);
        bus_stop();
        hw(4);
        wr_lock = 1'b0;
        chk(n_stb == s0 && n_commit == c0, "R6 no strobe or commit", n_stb - s0 + n_commit - c0, 0);
        rd_check(8'h02, 8'h00, 2, 13'h0200, "R6 memory unchanged");

        // R8: current address reads after a random read
        rd_check(8'h03, 8'h00, 1, 13'h0300, "R8 setup");
        cur_check(1, 13'h0301, "R8 current read");
        cur_check(2, 13'h0302, "R8 current read again");

        // R9: sequential read across the top of the array
        rd_check(8'h1F, 8'hFE, 4, 13'h1FFE, "R9 sequential wrap");

        // R11: upper address bits ignored
        rd_check(8'hE4, 8'h5E, 1, 13'h045E, "R11 upper bits ignored");

        // R12: aborted writes do not commit
        c0 = n_commit;
        addr_phase(8'h05, 8'h00, "R12");
        bus_stop();
        bus_start();
        send_byte(DEV_W, a);
        send_byte(8'h05, a);
        bus_start();
        send_byte(DEV_W, a); chk(a, "R12 select ack, not busy", a, 1);
        bus_stop();
        hw(4);
        chk(n_commit == c0 && !busy, "R12 no commit", n_commit, c0);

        summary();
    end
endmodule